// File: doc/BRIEF.md
# Strap-Latched Clock Output Mode Controller

This block is the digital control layer of a multi-output clock generator. While reset is held it reads the frequency-select and top-CPU straps from pins that are shared with clock outputs. When reset is released it keeps that captured value and uses it to choose one mode for all output groups.

In normal mode each output group carries its own source clock. In test mode every output is derived from one external test clock, either passed straight through or divided by two or by four. Two strap codes produce a quiet state: every output is low and the output-enable flags are cleared, so the pads can be tri-stated.

Per-output enable bits come from a register block elsewhere on the chip. An enable bit is taken into effect only at a sample where that output's source is low, so a pulse is never cut short or started part-way. One memory clock output ignores the enable bits completely.

All clock inputs are treated as oversampled levels in the `clk` domain. Every output is a flop.

Top module: `clk_strap_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output, `oe_o` and `oe_cpu_top_o` are 0. The strap pins are captured at every reset cycle, and the value present at the last reset cycle is the one kept.
- R2: The kept `fs_pin_i` value selects the mode: 2'b11 is normal, 2'b10 is test, and 2'b00 is quiet. In quiet mode all outputs and both enable flags stay 0. In normal or test mode `oe_o` rises at the first clock edge after reset is released and does not fall until the next reset.
- R3: In normal mode each output shows its source one clock later: `cpu_o` and `mref_o` follow `src_cpu_i`, `pci_o` and `apic_o` follow `src_pci_i`, `clk48_o` follows `src_48m_i`, and `ref_o` follows `src_ref_i`.
- R4: In test mode a rising-edge count n of `tclk_i` starts at 0 at reset. `cpu_o`, `mref_o` and `clk48_o` carry bit 0 of n, `pci_o` and `apic_o` carry bit 1 of n, and `ref_o` carries `tclk_i`. Every test output lags the `tclk_i` sample by two clock edges.
- R5: In both normal and test mode, `sdram_o` follows `buf_in_i` one clock later.
- R6: The enable bits map one to one: `en_sdram_i[i]` gates `sdram_o[i]` and `en_pci_i[i]` gates `pci_o[i]`. For `en_48m_i`, bit 0 gates `clk48_o[0]` (display clock) and bit 1 gates `clk48_o[1]` (USB clock). A gated output stays 0.
- R7: A change of an enable bit, the top-CPU strap, or the always-on enables after reset is taken into effect only at a clock edge where that output's selected source samples low. After reset every gate starts closed.
- R8: `sdram_free_o` follows `buf_in_i` one clock later in normal and test mode, whatever the enable bits are.
- R9: If the top-CPU strap was kept low, `cpu_o[N_CPU-1]` runs and `oe_cpu_top_o` follows `oe_o`. If it was kept high, that output stays 0 and `oe_cpu_top_o` stays 0.
- R10: Changes on the strap pins after reset release have no effect on any output.
- R11: Strap code 2'b01 (reserved) behaves exactly as quiet mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, oversamples every clock input |
| rst_n | input | 1 | Synchronous active-low power-on reset; straps are read while low |
| fs_pin_i | input | 2 | Frequency-select strap pins |
| cpu_top_pin_i | input | 1 | Top-CPU strap, low enables the top CPU output |
| src_cpu_i | input | 1 | CPU group source clock |
| src_pci_i | input | 1 | PCI and interrupt-controller group source clock |
| src_48m_i | input | 1 | 48 MHz group source clock |
| src_ref_i | input | 1 | Reference group source clock |
| buf_in_i | input | 1 | Memory fan-out buffer input clock |
| tclk_i | input | 1 | External test clock |
| en_sdram_i | input | N_SDR | Per-output memory clock enables |
| en_pci_i | input | N_PCI | Per-output PCI clock enables |
| en_48m_i | input | 2 | 48 MHz enables, bit 0 display, bit 1 USB |
| cpu_o | output | N_CPU | CPU clocks |
| mref_o | output | 1 | Memory reference clock |
| pci_o | output | N_PCI | PCI clocks |
| apic_o | output | N_APIC | Interrupt-controller clocks |
| sdram_o | output | N_SDR | Gated memory clocks |
| sdram_free_o | output | 1 | Free-running memory clock |
| clk48_o | output | 2 | 48 MHz clocks |
| ref_o | output | N_REF | Reference clocks |
| oe_o | output | 1 | Pad enable for all outputs except the top CPU output |
| oe_cpu_top_o | output | 1 | Pad enable for the top CPU output |

## Verification
A wrong strap capture or mode decode shows on the first clock edge after reset release. It appears as a wrong `oe_o` or `oe_cpu_top_o` level and as outputs that follow the wrong source. A divider that is off by a phase appears within a few `tclk_i` edges, as a test output that disagrees with the edge count. A gate that takes in an enable change while its source is high shows as a pulse that is shortened or started late, at the first source cycle after the change. Comparing every output against the reference model at every clock exposes each of these within one source period.

// File: rtl/clkmode_pkg.sv
// Package: shared mode type and strap decode for the clock output controller.
// Assumes the strap code is given as pin levels (not as the stored inverse).
package clkmode_pkg;

    localparam int FS_W = 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_TEST   = 2'd1,
        MODE_RSVD   = 2'd2,
        MODE_OFF    = 2'd3
    } outmode_e;

    // Map a frequency-select pin code to an output mode.
    function automatic outmode_e decode_mode(input logic [FS_W-1:0] pins);
        case (pins)
            2'b11:   decode_mode = MODE_NORMAL;
            2'b10:   decode_mode = MODE_TEST;
            2'b01:   decode_mode = MODE_RSVD;
            default: decode_mode = MODE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/strap_capture.sv
// strap_capture: reads the shared strap pins on every clock while reset is
// low and holds the last value afterwards. The frequency-select code is kept
// inverted, as the register block expects, and is turned back into pin
// levels for decoding. Assumes rst_n is held low for at least one clock.
module strap_capture
    import clkmode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] fs_pin_i,
    input  logic            cpu_top_pin_i,
    output outmode_e        mode_o,
    output logic            cpu_top_on_o
);

    logic [FS_W-1:0] fs_inv_q;
    logic            top_pin_q;

    // Capture the straps during reset, hold them after release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_inv_q  <= ~fs_pin_i;
            top_pin_q <= cpu_top_pin_i;
        end
    end

    // Decode the pin-level code and the active-low top-CPU strap.
    always_comb begin
        mode_o       = decode_mode(~fs_inv_q);
        cpu_top_on_o = ~top_pin_q;
    end

endmodule

// File: rtl/tclk_divider.sv
// tclk_divider: samples the external test clock into the controller domain
// and derives the divide-by-2 and divide-by-4 phases from its rising edges.
// Reset clears all phases, so the divided outputs start aligned. Assumes the
// test clock is slower than half the controller clock.
module tclk_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_i,
    output logic tclk_q_o,
    output logic div2_o,
    output logic div4_o
);

    logic tclk_rise;

    // Rising edge of the sampled test clock.
    always_comb tclk_rise = tclk_i & ~tclk_q_o;

    // Sample the test clock and step the divider chain on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclk_q_o <= 1'b0;
            div2_o   <= 1'b0;
            div4_o   <= 1'b0;
        end else begin
            tclk_q_o <= tclk_i;
            if (tclk_rise) begin
                div2_o <= ~div2_o;
                if (div2_o) begin
                    div4_o <= ~div4_o;
                end
            end
        end
    end

endmodule

// File: rtl/glitchfree_gate_bank.sv
// glitchfree_gate_bank: N output gates. Each gate takes a new enable value
// only at a sample where its own source is low, so a high pulse is never
// shortened or started part-way. The output is a flop. Assumes the enables
// are already stable in the clk domain.
module glitchfree_gate_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] out_o
);

    logic [N-1:0] en_q;

    for (genvar g = 0; g < N; g++) begin : g_gate
        // Update the enable while the source is low; register the output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]  <= 1'b0;
                out_o[g] <= 1'b0;
            end else begin
                out_o[g] <= active_i & en_q[g] & src_i[g];
                if (!src_i[g]) begin
                    en_q[g] <= en_i[g];
                end
            end
        end
    end

endmodule

// File: rtl/clk_strap_mode_ctrl.sv
// clk_strap_mode_ctrl: top of the clock output mode controller. It captures
// the straps at reset, then selects normal sources or test-clock phases for
// each group, gates every output glitch-free, and drives the pad enables.
// Assumes every clock input is a level oversampled by clk.
module clk_strap_mode_ctrl
    import clkmode_pkg::*;
#(
    parameter int N_CPU  = 3,
    parameter int N_PCI  = 8,
    parameter int N_APIC = 2,
    parameter int N_SDR  = 8,
    parameter int N_REF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FS_W-1:0]   fs_pin_i,
    input  logic              cpu_top_pin_i,
    input  logic              src_cpu_i,
    input  logic              src_pci_i,
    input  logic              src_48m_i,
    input  logic              src_ref_i,
    input  logic              buf_in_i,
    input  logic              tclk_i,
    input  logic [N_SDR-1:0]  en_sdram_i,
    input  logic [N_PCI-1:0]  en_pci_i,
    input  logic [1:0]        en_48m_i,
    output logic [N_CPU-1:0]  cpu_o,
    output logic              mref_o,
    output logic [N_PCI-1:0]  pci_o,
    output logic [N_APIC-1:0] apic_o,
    output logic [N_SDR-1:0]  sdram_o,
    output logic              sdram_free_o,
    output logic [1:0]        clk48_o,
    output logic [N_REF-1:0]  ref_o,
    output logic              oe_o,
    output logic              oe_cpu_top_o
);

    localparam int N_48    = 2;
    localparam int N_LOWER = N_CPU - 1;

    outmode_e mode;
    logic     cpu_top_on;
    logic     active;
    logic     test_sel;
    logic     tclk_q, div2, div4;
    logic     cpu_src, pci_src, c48_src, ref_src;

    strap_capture u_straps (
        .clk          (clk),
        .rst_n        (rst_n),
        .fs_pin_i     (fs_pin_i),
        .cpu_top_pin_i(cpu_top_pin_i),
        .mode_o       (mode),
        .cpu_top_on_o (cpu_top_on)
    );

    tclk_divider u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tclk_i  (tclk_i),
        .tclk_q_o(tclk_q),
        .div2_o  (div2),
        .div4_o  (div4)
    );

    // Mode flags and per-group source selection.
    always_comb begin
        active   = (mode == MODE_NORMAL) || (mode == MODE_TEST);
        test_sel = (mode == MODE_TEST);
        cpu_src  = test_sel ? div2   : src_cpu_i;
        pci_src  = test_sel ? div4   : src_pci_i;
        c48_src  = test_sel ? div2   : src_48m_i;
        ref_src  = test_sel ? tclk_q : src_ref_i;
    end

    glitchfree_gate_bank #(.N(N_CPU)) u_cpu (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_CPU{cpu_src}}),
        .en_i    ({cpu_top_on, {N_LOWER{1'b1}}}),
        .out_o   (cpu_o)
    );

    glitchfree_gate_bank #(.N(1)) u_mref (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   (cpu_src),
        .en_i    (1'b1),
        .out_o   (mref_o)
    );

    glitchfree_gate_bank #(.N(N_PCI)) u_pci (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_PCI{pci_src}}),
        .en_i    (en_pci_i),
        .out_o   (pci_o)
    );

    glitchfree_gate_bank #(.N(N_APIC)) u_apic (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_APIC{pci_src}}),
        .en_i    ({N_APIC{1'b1}}),
        .out_o   (apic_o)
    );

    glitchfree_gate_bank #(.N(N_SDR)) u_sdram (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_SDR{buf_in_i}}),
        .en_i    (en_sdram_i),
        .out_o   (sdram_o)
    );

    glitchfree_gate_bank #(.N(N_48)) u_c48 (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_48{c48_src}}),
        .en_i    (en_48m_i),
        .out_o   (clk48_o)
    );

    glitchfree_gate_bank #(.N(N_REF)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .src_i   ({N_REF{ref_src}}),
        .en_i    ({N_REF{1'b1}}),
        .out_o   (ref_o)
    );

    // Free-running memory clock and pad enables, all registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdram_free_o <= 1'b0;
            oe_o         <= 1'b0;
            oe_cpu_top_o <= 1'b0;
        end else begin
            sdram_free_o <= active & buf_in_i;
            oe_o         <= active;
            oe_cpu_top_o <= active & cpu_top_on;
        end
    end

endmodule

// File: rtl/clk_strap_mode_chk.sv
// clk_strap_mode_chk: port-level properties of the clock output controller,
// attached to every instance of the top module by the bind below.
module clk_strap_mode_chk #(
    parameter int N_CPU  = 3,
    parameter int N_PCI  = 8,
    parameter int N_APIC = 2,
    parameter int N_SDR  = 8,
    parameter int N_REF  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_in_i,
    input logic [N_CPU-1:0]  cpu_o,
    input logic              mref_o,
    input logic [N_PCI-1:0]  pci_o,
    input logic [N_APIC-1:0] apic_o,
    input logic [N_SDR-1:0]  sdram_o,
    input logic              sdram_free_o,
    input logic [1:0]        clk48_o,
    input logic [N_REF-1:0]  ref_o,
    input logic              oe_o,
    input logic              oe_cpu_top_o
);

    // R2
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$fell(oe_o));

    // R11
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (cpu_o == '0 && !mref_o && pci_o == '0 && apic_o == '0 &&
                   sdram_o == '0 && !sdram_free_o && clk48_o == '0 && ref_o == '0));

    // R9
    top_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_cpu_top_o |-> oe_o);

    // R9
    top_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_cpu_top_o |-> !cpu_o[N_CPU-1]);

    // R8
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> (sdram_free_o == $past(buf_in_i)));

    for (genvar g = 0; g < N_SDR; g++) begin : g_runt
        // R7
        no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $fell(sdram_o[g])) |-> !$past(buf_in_i));
    end

endmodule

bind clk_strap_mode_ctrl clk_strap_mode_chk #(
    .N_CPU (N_CPU),
    .N_PCI (N_PCI),
    .N_APIC(N_APIC),
    .N_SDR (N_SDR),
    .N_REF (N_REF)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_in_i    (buf_in_i),
    .cpu_o       (cpu_o),
    .mref_o      (mref_o),
    .pci_o       (pci_o),
    .apic_o      (apic_o),
    .sdram_o     (sdram_o),
    .sdram_free_o(sdram_free_o),
    .clk48_o     (clk48_o),
    .ref_o       (ref_o),
    .oe_o        (oe_o),
    .oe_cpu_top_o(oe_cpu_top_o)
);

// File: tb/clk_strap_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock reference model compared on every cycle.
module clk_strap_mode_ctrl_tb_top;

    localparam int N_CPU  = 3;
    localparam int N_PCI  = 8;
    localparam int N_APIC = 2;
    localparam int N_SDR  = 8;
    localparam int N_REF  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] fs_pin = 2'b11;
    logic top_pin = 1'b0;
    logic src_cpu = 0, src_pci = 0, src_48 = 0, src_ref = 0, buf_in = 0, tclk = 0;
    logic [N_SDR-1:0] en_sdr = '1;
    logic [N_PCI-1:0] en_pci = '1;
    logic [1:0]       en_48 = 2'b11;

    logic [N_CPU-1:0]  cpu_o;
    logic              mref_o;
    logic [N_PCI-1:0]  pci_o;
    logic [N_APIC-1:0] apic_o;
    logic [N_SDR-1:0]  sdram_o;
    logic              sdram_free_o;
    logic [1:0]        clk48_o;
    logic [N_REF-1:0]  ref_o;
    logic              oe_o, oe_cpu_top_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tdiv = 1;
    string phase = "";

    always #2.5 clk = ~clk;

    clk_strap_mode_ctrl #(
        .N_CPU(N_CPU), .N_PCI(N_PCI), .N_APIC(N_APIC), .N_SDR(N_SDR), .N_REF(N_REF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fs_pin_i(fs_pin), .cpu_top_pin_i(top_pin),
        .src_cpu_i(src_cpu), .src_pci_i(src_pci), .src_48m_i(src_48),
        .src_ref_i(src_ref), .buf_in_i(buf_in), .tclk_i(tclk),
        .en_sdram_i(en_sdr), .en_pci_i(en_pci), .en_48m_i(en_48),
        .cpu_o(cpu_o), .mref_o(mref_o), .pci_o(pci_o), .apic_o(apic_o),
        .sdram_o(sdram_o), .sdram_free_o(sdram_free_o), .clk48_o(clk48_o),
        .ref_o(ref_o), .oe_o(oe_o), .oe_cpu_top_o(oe_cpu_top_o)
    );

    // ---------------- reference model ----------------
    logic [1:0] m_fs;
    logic m_top, m_inrst = 1'b1, m_act = 1'b0, m_tst = 1'b0, m_tq = 1'b0;
    int   m_cnt = 0;
    logic s_cpu, s_pci, s_48, s_ref;
    logic [N_CPU-1:0]  e_cpu = '0, x_cpu = '0;
    logic              e_mref = 0, x_mref = 0;
    logic [N_PCI-1:0]  e_pci = '0, x_pci = '0;
    logic [N_APIC-1:0] e_apic = '0, x_apic = '0;
    logic [N_SDR-1:0]  e_sdr = '0, x_sdr = '0;
    logic [1:0]        e_48 = '0, x_48 = '0;
    logic [N_REF-1:0]  e_ref = '0, x_ref = '0;
    logic x_free = 0, x_oe = 0, x_oetop = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_inrst = 1'b1;
            m_fs = fs_pin; m_top = top_pin;
            m_act = 0; m_tst = 0; m_cnt = 0; m_tq = 0;
            e_cpu = '0; e_mref = 0; e_pci = '0; e_apic = '0; e_sdr = '0; e_48 = '0; e_ref = '0;
            x_cpu = '0; x_mref = 0; x_pci = '0; x_apic = '0; x_sdr = '0; x_48 = '0; x_ref = '0;
            x_free = 0; x_oe = 0; x_oetop = 0;
        end else begin
            m_inrst = 1'b0;
            m_act = (m_fs == 2'b11) || (m_fs == 2'b10);
            m_tst = (m_fs == 2'b10);
            s_cpu = m_tst ? logic'(m_cnt % 2)       : src_cpu;
            s_pci = m_tst ? logic'((m_cnt / 2) % 2) : src_pci;
            s_48  = m_tst ? logic'(m_cnt % 2)       : src_48;
            s_ref = m_tst ? m_tq                    : src_ref;
            for (int i = 0; i < N_CPU; i++) begin
                x_cpu[i] = m_act & e_cpu[i] & s_cpu;
                if (!s_cpu) e_cpu[i] = (i == N_CPU - 1) ? !m_top : 1'b1;
            end
            x_mref = m_act & e_mref & s_cpu;
            if (!s_cpu) e_mref = 1'b1;
            for (int i = 0; i < N_PCI; i++) begin
                x_pci[i] = m_act & e_pci[i] & s_pci;
                if (!s_pci) e_pci[i] = en_pci[i];
            end
            for (int i = 0; i < N_APIC; i++) begin
                x_apic[i] = m_act & e_apic[i] & s_pci;
                if (!s_pci) e_apic[i] = 1'b1;
            end
            for (int i = 0; i < N_SDR; i++) begin
                x_sdr[i] = m_act & e_sdr[i] & buf_in;
                if (!buf_in) e_sdr[i] = en_sdr[i];
            end
            for (int i = 0; i < 2; i++) begin
                x_48[i] = m_act & e_48[i] & s_48;
                if (!s_48) e_48[i] = en_48[i];
            end
            for (int i = 0; i < N_REF; i++) begin
                x_ref[i] = m_act & e_ref[i] & s_ref;
                if (!s_ref) e_ref[i] = 1'b1;
            end
            x_free  = m_act & buf_in;
            x_oe    = m_act;
            x_oetop = m_act & !m_top;
            if (tclk && !m_tq) m_cnt = m_cnt + 1;
            m_tq = tclk;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic compare();
        string base, t_main, t_gate;
        if (m_inrst) base = "R1";
        else if (!m_act) base = (m_fs == 2'b01) ? "R11" : "R2";
        else base = "";
        t_main = (base != "") ? base : (m_tst ? "R4" : "R3");
        t_gate = (base != "") ? base : (m_tst ? "R4 R6" : "R6");
        check({t_main, " cpu ", phase}, 32'(cpu_o[N_CPU-2:0]), 32'(x_cpu[N_CPU-2:0]));
        check({(base != "") ? base : "R9", " cpu top ", phase}, 32'(cpu_o[N_CPU-1]), 32'(x_cpu[N_CPU-1]));
        check({t_main, " mref ", phase}, 32'(mref_o), 32'(x_mref));
        check({t_gate, " pci ", phase}, 32'(pci_o), 32'(x_pci));
        check({t_main, " apic ", phase}, 32'(apic_o), 32'(x_apic));
        check({(base != "") ? base : "R5 R6", " sdram ", phase}, 32'(sdram_o), 32'(x_sdr));
        check({(base != "") ? base : "R8", " free ", phase}, 32'(sdram_free_o), 32'(x_free));
        check({t_gate, " 48m ", phase}, 32'(clk48_o), 32'(x_48));
        check({t_main, " ref ", phase}, 32'(ref_o), 32'(x_ref));
        check({(base != "") ? base : "R2", " oe ", phase}, 32'(oe_o), 32'(x_oe));
        check({(base != "") ? base : "R9", " oe top ", phase}, 32'(oe_cpu_top_o), 32'(x_oetop));
    endtask

    // One cycle: compare away from the edge, then drive the next inputs.
    task automatic step(input int n, input bit rand_en);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare();
            cyc++;
            src_cpu = logic'((cyc / 2) % 2);
            src_pci = logic'((cyc / 4) % 2);
            src_48  = logic'((cyc / 3) % 2);
            src_ref = logic'((cyc / 7) % 2);
            buf_in  = logic'(((cyc + 1) / 2) % 2);
            tclk    = logic'((cyc / tdiv) % 2);
            if (rand_en && ($urandom % 4 == 0)) begin
                en_sdr = N_SDR'($urandom);
                en_pci = N_PCI'($urandom);
                en_48  = 2'($urandom);
            end
        end
    endtask

    // Reset with decoy straps first, final straps in the last reset cycles (R1).
    task automatic do_reset(input logic [1:0] fs, input logic top);
        phase = "R1 capture";
        rst_n = 1'b0;
        fs_pin = ~fs; top_pin = ~top;
        step(3, 0);
        fs_pin = fs; top_pin = top;
        step(2, 0);
        rst_n = 1'b1;
        phase = "";
    endtask

    initial begin
        // Normal mode, top CPU on, random enable changes (R3, R6, R7).
        do_reset(2'b11, 1'b0);
        phase = "R7 normal";
        step(300, 1);
        // Enables all off then on again (R6, R8 free output unaffected).
        en_sdr = '0; en_pci = '0; en_48 = '0;
        phase = "R8 enables off";
        step(40, 0);
        en_sdr = '1; en_pci = '1; en_48 = 2'b11;
        step(20, 0);
        // Straps wiggle after release (R10).
        phase = "R10 straps moved";
        for (int k = 0; k < 60; k++) begin
            fs_pin = 2'($urandom);
            top_pin = 1'($urandom);
            step(1, 1);
        end
        // Test mode, top CPU off, several test clock rates (R4, R9).
        tdiv = 1;
        do_reset(2'b10, 1'b1);
        phase = "R4 tclk/1";
        step(120, 1);
        tdiv = 3;
        phase = "R4 tclk/3";
        step(150, 1);
        tdiv = 2;
        do_reset(2'b10, 1'b0);
        phase = "R4 tclk/2 top on";
        step(150, 1);
        // Reserved code (R11) and quiet code (R2).
        do_reset(2'b01, 1'b0);
        phase = "R11 reserved";
        step(60, 1);
        do_reset(2'b00, 1'b0);
        phase = "R2 quiet";
        step(60, 1);
        // Back to normal with top strap high (R9).
        do_reset(2'b11, 1'b1);
        phase = "R9 top off";
        step(100, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog R1 got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule